// File: doc/BRIEF.md
# Phased Instruction Field Distributor

This block carries a 20-bit instruction word from the chip's external instruction pins to an array of processing elements. It uses a shared 5-bit broadcast bus instead of a 20-bit parallel bus. The distributor runs on a clock four times faster than the instruction rate. It accepts one external word per instruction slot through a valid/ready handshake. It then drives the word's four 5-bit fields onto the bus, one per fast cycle, with a 2-bit phase indicator next to the bus.

Each element has a receiver. The receiver captures the field that belongs to the current phase into its own register. After the last field it presents the whole reassembled instruction and pulses an execute strobe for one fast cycle. When the external source has nothing to offer in a slot, the distributor fills the slot with a no-operation word, so the elements keep stepping in lock-step. The fast clock itself is outside this block. A phase counter on the single clock `clk` stands in for the division into slots.

Top module: `instr_field_dist`

## Requirements
- R1: An instruction word is 20 bits, packed as opcode [19:15], first read address [14:10], second read address [9:5] and write address [4:0].
- R2: The bus phase counts 0, 1, 2, 3 and then wraps to 0 on every clock after reset. In phase k the bus carries field k, in the order opcode, first read address, second read address, write address.
- R3: `in_ready` is high only in phase 3, the last phase of the word being sent. A word with `in_valid` high in that cycle is taken at the following edge. It is then driven over the next four cycles and held unchanged for all of them.
- R4: If `in_valid` is low in the phase-3 cycle, the next slot carries a no-operation word. This word has opcode 0 and both read addresses 0. Its write address is `NOP_WADDR` (default 31), the constant-zero location.
- R5: Each receiver raises `out_exec` for exactly one cycle. That cycle is the one after phase 3, in which the bus phase is 0. `out_instr` then holds the word that was sent in the slot just finished.
- R6: Between strobes, each receiver's `out_instr` does not change.
- R7: While `rst_n` is low at a clock edge, the phase returns to 0, the word being sent becomes the no-operation word, all receiver field and instruction registers clear to 0, and `out_exec` goes low.
- R8: Every receiver in the array reassembles the same instruction and strobes in the same cycle.
- R9: Reassembled instructions come out in the order the words were accepted. No word is lost or repeated, and a no-operation word appears for each empty slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, four cycles per instruction slot |
| rst_n | input | 1 | Synchronous active-low reset |
| in_word | input | 20 | Instruction word from the external pins |
| in_valid | input | 1 | `in_word` is offered |
| in_ready | output | 1 | Word is taken at the next edge if `in_valid` is high |
| bus_field | output | 5 | Shared narrow field bus |
| bus_phase | output | 2 | Index of the field on `bus_field` |
| out_instr | output | 80 | Reassembled instruction per element, element 0 in the low 20 bits |
| out_exec | output | 4 | Execute strobe per element |

## Verification
The assertions assume the external source follows the handshake. Once it raises `in_valid`, it keeps both `in_valid` and `in_word` unchanged until a phase-3 cycle takes the word. The bench keeps to this rule. It draws a new word only after the previous one has been taken, and otherwise holds its inputs at the falling edge. Beyond that, the assertions rely only on reset being asserted for at least one edge before operation starts. The bench holds reset for several edges.

// File: rtl/idp_pkg.sv
// Package: shared defaults for the phased instruction field distributor.
// Assumes the instruction is a whole number of equal-width fields.
package idp_pkg;
    localparam int DEF_FIELD_W    = 5;
    localparam int DEF_NUM_FIELDS = 4;
    localparam int DEF_NUM_ELEM   = 4;
    localparam int DEF_NOP_WADDR  = 31;
endpackage

// File: rtl/idp_phase_ctr.sv
// Module: idp_phase_ctr
// Counts the field phases of one instruction slot. It wraps after the
// last field. Assumes NUM_FIELDS >= 2. Reset is synchronous and active low.
module idp_phase_ctr #(
    parameter int NUM_FIELDS = idp_pkg::DEF_NUM_FIELDS,
    localparam int PH_W = $clog2(NUM_FIELDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase
);
    localparam logic [PH_W-1:0] LAST = PH_W'(NUM_FIELDS - 1);

    logic [PH_W-1:0] phase_q;

    // Advance the phase each cycle and wrap after the last field.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_q == LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    assign phase = phase_q;

    assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != LAST) |=> (phase_q == $past(phase_q) + 1'b1));
    assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == LAST) |=> (phase_q == '0));
endmodule

// File: rtl/idp_sender.sv
// Module: idp_sender
// Takes one external word per slot through a valid/ready handshake and
// drives its fields onto the narrow bus, most significant field first.
// A no-operation word fills any slot that has no valid word.
// Assumes the source holds valid and word steady until they are taken.
module idp_sender #(
    parameter int FIELD_W    = idp_pkg::DEF_FIELD_W,
    parameter int NUM_FIELDS = idp_pkg::DEF_NUM_FIELDS,
    parameter int NOP_WADDR  = idp_pkg::DEF_NOP_WADDR,
    localparam int PH_W      = $clog2(NUM_FIELDS),
    localparam int INSTR_W   = FIELD_W * NUM_FIELDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PH_W-1:0]    phase,
    input  logic [INSTR_W-1:0] in_word,
    input  logic               in_valid,
    output logic               in_ready,
    output logic [FIELD_W-1:0] bus_field
);
    localparam logic [PH_W-1:0]    LAST = PH_W'(NUM_FIELDS - 1);
    localparam logic [INSTR_W-1:0] NOP_WORD = INSTR_W'(NOP_WADDR);

    logic [INSTR_W-1:0] word_q;

    // Accept a new word only in the last phase of the word now being sent.
    assign in_ready = (phase == LAST);

    // Load the next slot's word, or the no-operation word if none is offered.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= NOP_WORD;
        else if (in_ready)
            word_q <= in_valid ? in_word : NOP_WORD;
    end

    // Select the field for the current phase, starting from the top bits.
    always_comb begin
        bus_field = word_q[INSTR_W - 1 - int'(phase) * FIELD_W -: FIELD_W];
    end

    assert_word_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != LAST) |=> $stable(word_q));
    assert_nop_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> (word_q == NOP_WORD));
    assert_take_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |=> (word_q == $past(in_word)));
endmodule

// File: rtl/idp_receiver.sv
// Module: idp_receiver
// One element's receiver. It stores each field in its own register in
// that field's phase. On the last field it loads the whole instruction
// and pulses the execute strobe for one cycle. Assumes the bus and phase
// come from one sender on the same clock.
module idp_receiver #(
    parameter int FIELD_W    = idp_pkg::DEF_FIELD_W,
    parameter int NUM_FIELDS = idp_pkg::DEF_NUM_FIELDS,
    localparam int PH_W      = $clog2(NUM_FIELDS),
    localparam int INSTR_W   = FIELD_W * NUM_FIELDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] bus_field,
    input  logic [PH_W-1:0]    bus_phase,
    output logic [INSTR_W-1:0] instr,
    output logic               exec
);
    localparam logic [PH_W-1:0] LAST = PH_W'(NUM_FIELDS - 1);

    logic [FIELD_W-1:0] field_q [NUM_FIELDS-1];
    logic [INSTR_W-1:0] instr_q;
    logic [INSTR_W-1:0] assembled;
    logic               exec_q;

    // One capture register for every field except the last.
    for (genvar k = 0; k < NUM_FIELDS - 1; k++) begin : g_field
        // Capture field k when its phase is on the bus.
        always_ff @(posedge clk) begin
            if (!rst_n)
                field_q[k] <= '0;
            else if (bus_phase == PH_W'(k))
                field_q[k] <= bus_field;
        end
        assign assembled[INSTR_W - 1 - k * FIELD_W -: FIELD_W] = field_q[k];
    end
    assign assembled[FIELD_W-1:0] = bus_field;

    // Load the full instruction and strobe once the last field arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr_q <= '0;
            exec_q  <= 1'b0;
        end else begin
            exec_q <= (bus_phase == LAST);
            if (bus_phase == LAST)
                instr_q <= assembled;
        end
    end

    assign instr = instr_q;
    assign exec  = exec_q;

    assert_exec_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exec_q |=> !exec_q);
    assert_exec_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exec_q |-> (bus_phase == '0));
    assert_instr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_q |-> $stable(instr_q));
endmodule

// File: rtl/instr_field_dist.sv
// Module: instr_field_dist
// Top level: phase counter, one sender and an array of element receivers
// that share the narrow field bus. The phase counter stands in for the
// fast clock's division into instruction slots.
module instr_field_dist #(
    parameter int FIELD_W    = idp_pkg::DEF_FIELD_W,
    parameter int NUM_FIELDS = idp_pkg::DEF_NUM_FIELDS,
    parameter int NUM_ELEM   = idp_pkg::DEF_NUM_ELEM,
    parameter int NOP_WADDR  = idp_pkg::DEF_NOP_WADDR,
    localparam int PH_W      = $clog2(NUM_FIELDS),
    localparam int INSTR_W   = FIELD_W * NUM_FIELDS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [INSTR_W-1:0]          in_word,
    input  logic                        in_valid,
    output logic                        in_ready,
    output logic [FIELD_W-1:0]          bus_field,
    output logic [PH_W-1:0]             bus_phase,
    output logic [NUM_ELEM*INSTR_W-1:0] out_instr,
    output logic [NUM_ELEM-1:0]         out_exec
);
    logic [PH_W-1:0] phase;

    idp_phase_ctr #(.NUM_FIELDS(NUM_FIELDS)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    idp_sender #(
        .FIELD_W    (FIELD_W),
        .NUM_FIELDS (NUM_FIELDS),
        .NOP_WADDR  (NOP_WADDR)
    ) u_send (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .in_word   (in_word),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .bus_field (bus_field)
    );

    assign bus_phase = phase;

    // One receiver per element, all listening to the same bus.
    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
        idp_receiver #(
            .FIELD_W    (FIELD_W),
            .NUM_FIELDS (NUM_FIELDS)
        ) u_rx (
            .clk       (clk),
            .rst_n     (rst_n),
            .bus_field (bus_field),
            .bus_phase (phase),
            .instr     (out_instr[e*INSTR_W +: INSTR_W]),
            .exec      (out_exec[e])
        );
    end

    assert_ready_then_exec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> out_exec[0]);
    assert_elems_agree_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_exec[0] |-> (out_exec == {NUM_ELEM{1'b1}}));
endmodule

// File: tb/sim_instr_field_dist.sv
module sim_instr_field_dist;
    localparam int FW = 5;
    localparam int NE = 4;
    localparam int IW = 20;
    localparam logic [IW-1:0] NOP = 20'd31;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [IW-1:0]    in_word = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [FW-1:0]    bus_field;
    logic [1:0]       bus_phase;
    logic [NE*IW-1:0] out_instr;
    logic [NE-1:0]    out_exec;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    instr_field_dist u0 (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
        .in_ready(in_ready), .bus_field(bus_field), .bus_phase(bus_phase),
        .out_instr(out_instr), .out_exec(out_exec)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    logic [IW-1:0] exp_q[$];
    logic [IW-1:0] cur_word = NOP;
    logic [IW-1:0] last_instr = '0;
    logic [IW-1:0] nxt;
    logic [IW-1:0] e;
    bit            pending = 0;
    int            sweep_i = 0;
    int            cyc = 0;
    int            mode = 0;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7: reset state
        chk(out_exec == '0, "R7 exec", 64'(out_exec), 0);
        chk(out_instr == '0, "R7 instr", 64'(out_instr[IW-1:0]), 0);
        chk(bus_phase == 2'd0, "R7 phase", 64'(bus_phase), 0);
        chk(bus_field == 5'd0, "R7 opcode of nop", 64'(bus_field), 0);
        exp_q.push_back(NOP);
        rst_n = 1'b1;
        for (int n = 0; n < 2200; n++) begin
            // choose stimulus mode: sweep, random with stalls, idle, then sparse
            mode = (n < 160) ? 0 : (n < 1800) ? 1 : (n < 1900) ? 2 : 3;
            if (!pending) begin
                case (mode)
                    0: begin
                        nxt = {5'(sweep_i), ~5'(sweep_i), 5'(sweep_i) + 5'd7, 5'(sweep_i) ^ 5'h15};
                        in_valid = 1'b1; in_word = nxt; pending = 1;
                    end
                    1: begin
                        in_valid = ($urandom % 3) != 0;
                        in_word = 20'($urandom);
                        pending = in_valid;
                    end
                    2: begin in_valid = 1'b0; in_word = 20'($urandom); end
                    default: begin
                        in_valid = ($urandom % 7) == 0;
                        in_word = 20'($urandom);
                        pending = in_valid;
                    end
                endcase
            end
            #0;
            // R2: phase and field order
            chk(bus_phase == 2'(cyc % 4), "R2 phase", 64'(bus_phase), 64'(cyc % 4));
            chk(bus_field == cur_word[19 - 5*(cyc%4) -: 5], "R1/R2 field", 64'(bus_field),
                64'(cur_word[19 - 5*(cyc%4) -: 5]));
            // R3: ready only in phase 3
            chk(in_ready == ((cyc % 4) == 3), "R3 ready", 64'(in_ready), 64'((cyc % 4) == 3));
            // R5/R8: strobe timing across all elements
            if ((cyc % 4) == 0 && cyc >= 4) begin
                chk(out_exec == 4'hF, "R5/R8 exec", 64'(out_exec), 64'hF);
                e = exp_q.pop_front();
                for (int k = 0; k < NE; k++)
                    chk(out_instr[k*IW +: IW] == e, "R9/R8 instr", 64'(out_instr[k*IW +: IW]), 64'(e));
                last_instr = e;
            end else begin
                chk(out_exec == 4'h0, "R5 no exec", 64'(out_exec), 0);
                for (int k = 0; k < NE; k++)
                    chk(out_instr[k*IW +: IW] == last_instr, "R6 hold", 64'(out_instr[k*IW +: IW]),
                        64'(last_instr));
            end
            // record handshake; the word or the nop (R4) is sent next slot
            if ((cyc % 4) == 3) begin
                e = in_valid ? in_word : NOP;
                exp_q.push_back(e);
                if (in_valid) begin pending = 0; sweep_i++; end
            end
            @(negedge clk);
            if ((cyc % 4) == 3) cur_word = exp_q[exp_q.size()-1];
            cyc++;
        end
        // R7: reset mid-stream returns to the reset state
        rst_n = 1'b0;
        @(negedge clk);
        chk(out_exec == '0, "R7 exec after reset", 64'(out_exec), 0);
        chk(out_instr == '0, "R7 instr after reset", 64'(out_instr[IW-1:0]), 0);
        chk(bus_phase == 2'd0, "R7 phase after reset", 64'(bus_phase), 0);
        chk(bus_field == 5'd0, "R4 nop opcode after reset", 64'(bus_field), 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule